// File: doc/BRIEF.md
# Destination Address Filter

This block decides, for every received Ethernet frame, whether the frame is kept or dropped on the basis of its 48-bit destination address. Software loads a small table of station addresses and a command word through a simple register port. The receive path offers each destination address on a valid/ready input; one cycle later the block presents the verdict on a valid/ready output, together with the address class and which table entry, if any, matched.

The address is sorted into broadcast, multicast or unicast. Three accept-all bits admit whole classes. A table-compare bit admits frames whose address equals an enabled table entry, and a complement bit turns that test around so that a match rejects and a miss admits. The two paths are combined with OR. After reset nothing is enabled, so every frame is rejected until software configures the filter.

Back-pressure: `in_ready` is high when the output stage is empty or is being drained in the same cycle (`!res_valid || res_ready`). A lookup is taken on a clock edge where `in_valid && in_ready`. While `res_valid` is high and `res_ready` is low, the result holds every output steady and no new address is taken.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, the command word and all entry enables read as zero, `res_valid` is low, `in_ready` is high, and every address looked up before any register write is rejected.
- R2: Register map on byte offsets: command word at 0x00 (bits 4:0), entry enables at 0x04 (bit i enables entry i), entry i high word at 0x08+8i, entry i low word at 0x0C+8i (bits 31:16 kept). Reads return what was written, with unkept bits reading zero. Offsets outside the map read zero, and writes to them change nothing.
- R3: Entry packing: address byte 0 (the first byte on the wire, `in_addr[47:40]`) sits in high word bits 31:24, then bytes 1, 2 and 3 follow down to bits 7:0. Bytes 4 and 5 sit in low word bits 31:24 and 23:16.
- R4: Classification on `res_class`: all ones gives broadcast (2). Otherwise, `in_addr[40]` set gives multicast (1). Everything else is unicast (0).
- R5: Command bit 0 accepts every unicast address, bit 1 every multicast address, bit 2 every broadcast address.
- R6: With command bit 4 set and bit 3 clear, an address equal to an enabled entry is accepted. A disabled entry never matches.
- R7: With command bits 4 and 3 both set, a match with an enabled entry rejects and a miss accepts, unless an accept-all bit admits the class.
- R8: `res_hit` is high when any enabled entry equals the address, whatever the command word. `res_idx` gives the lowest matching index, and is 0 when there is no hit.
- R9: A lookup taken on an edge yields `res_valid` after that same edge. `in_ready` equals `!res_valid || res_ready`. A stalled result holds all result outputs stable.
- R10: A register write and a lookup on the same edge: the lookup is judged against the table and command word as they were before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| in_valid | input | 1 | Destination address offered |
| in_ready | output | 1 | Filter can take an address this cycle |
| in_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| res_valid | output | 1 | Verdict available |
| res_ready | input | 1 | Consumer takes the verdict |
| res_accept | output | 1 | 1 keeps the frame, 0 drops it |
| res_hit | output | 1 | An enabled entry matched |
| res_idx | output | IDX_W | Lowest matching entry index |
| res_class | output | 2 | 0 unicast, 1 multicast, 2 broadcast |

## Verification
The two functions that can meet in one cycle are a register update and a lookup. The bench provokes this by writing a new high word into the only matching entry on the same edge that takes an address equal to that entry's old contents. The verdict must still show an accept with a hit on that entry, and a repeat lookup of the same address afterwards must be rejected. A second overlap, between output stall and a new offer, is driven by holding `res_ready` low while a different address waits; the held verdict must stay unchanged until the drain edge, and the waiting address must be taken on that same edge.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam int MAC_W  = 48;
  localparam int WORD_W = 32;

  // register offsets
  localparam int OFF_CMD  = 'h00;
  localparam int OFF_ENA  = 'h04;
  localparam int OFF_TBL  = 'h08;
  localparam int ENTRY_SZ = 8;

  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2
  } frame_cls_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic tbl_cmp;
    logic tbl_inv;
    logic all_bc;
    logic all_mc;
    logic all_uc;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  function automatic frame_cls_e classify(input logic [MAC_W-1:0] a);
    if (&a)             return CLS_BCAST;
    else if (a[MAC_W-8]) return CLS_MCAST;
    else                return CLS_UCAST;
  endfunction

endpackage

// File: rtl/daf_regs.sv
module daf_regs
  import daf_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [WORD_W-1:0]               wdata,
  output logic [WORD_W-1:0]               rdata,
  output cmd_t                            cmd,
  output logic [N_ENTRIES-1:0]            ena,
  output logic [N_ENTRIES-1:0][MAC_W-1:0] tbl
);

  localparam int IDX_W   = $clog2(N_ENTRIES);
  localparam int TBL_END = OFF_TBL + ENTRY_SZ * N_ENTRIES;
  localparam int LO_W    = MAC_W - WORD_W;

  logic             in_tbl;
  logic             lo_half;
  logic [IDX_W-1:0] sel;
  logic             hit_cmd;
  logic             hit_ena;

  assign hit_cmd = (int'(addr) == OFF_CMD);
  assign hit_ena = (int'(addr) == OFF_ENA);
  assign in_tbl  = (int'(addr) >= OFF_TBL) && (int'(addr) < TBL_END) &&
                   (addr[1:0] == 2'b00);
  assign lo_half = addr[2];
  assign sel     = IDX_W'((int'(addr) - OFF_TBL) / ENTRY_SZ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd <= '0;
      ena <= '0;
    end else if (we) begin
      if (hit_cmd) cmd <= cmd_t'(wdata[CMD_W-1:0]);
      if (hit_ena) ena <= wdata[N_ENTRIES-1:0];
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    logic wr_this;
    assign wr_this = we && in_tbl && (sel == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[g] <= '0;
      end else if (wr_this) begin
        if (lo_half) tbl[g][LO_W-1:0]     <= wdata[WORD_W-1 -: LO_W];
        else         tbl[g][MAC_W-1:LO_W] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_cmd) begin
      rdata = WORD_W'(cmd);
    end else if (hit_ena) begin
      rdata = WORD_W'(ena);
    end else if (in_tbl) begin
      if (lo_half) rdata = {tbl[sel][LO_W-1:0], {(WORD_W-LO_W){1'b0}}};
      else         rdata = tbl[sel][MAC_W-1:LO_W];
    end
  end

endmodule

// File: rtl/daf_match.sv
module daf_match
  import daf_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0][MAC_W-1:0] tbl,
  input  logic [N_ENTRIES-1:0]            ena,
  input  logic [MAC_W-1:0]                key,
  output logic                            hit,
  output logic [IDX_W-1:0]                idx
);

  logic [N_ENTRIES-1:0] eq;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign eq[g] = ena[g] && (tbl[g] == key);
  end

  assign hit = |eq;

  // lowest index wins
  always_comb begin
    idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/daf_decide.sv
module daf_decide
  import daf_pkg::*;
(
  input  cmd_t             cmd,
  input  logic [MAC_W-1:0] key,
  input  logic             hit,
  output logic             accept,
  output frame_cls_e       cls
);

  logic class_ok;
  logic table_ok;

  assign cls = classify(key);

  always_comb begin
    unique case (cls)
      CLS_BCAST: class_ok = cmd.all_bc;
      CLS_MCAST: class_ok = cmd.all_mc;
      default:   class_ok = cmd.all_uc;
    endcase
  end

  assign table_ok = cmd.tbl_cmp && (hit ^ cmd.tbl_inv);
  assign accept   = class_ok || table_ok;

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int  N_ENTRIES = 16,
  parameter int  ADDR_W    = 8,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [47:0]       in_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_accept,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_idx,
  output logic [1:0]        res_class
);

  cmd_t                            cmd_q;
  logic [N_ENTRIES-1:0]            ena_q;
  logic [N_ENTRIES-1:0][MAC_W-1:0] tbl_q;
  logic                            m_hit;
  logic [IDX_W-1:0]                m_idx;
  logic                            d_acc;
  frame_cls_e                      d_cls;

  daf_regs #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cmd   (cmd_q),
    .ena   (ena_q),
    .tbl   (tbl_q)
  );

  daf_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .tbl (tbl_q),
    .ena (ena_q),
    .key (in_addr),
    .hit (m_hit),
    .idx (m_idx)
  );

  daf_decide u_decide (
    .cmd    (cmd_q),
    .key    (in_addr),
    .hit    (m_hit),
    .accept (d_acc),
    .cls    (d_cls)
  );

  assign in_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_hit    <= 1'b0;
      res_idx    <= '0;
      res_class  <= CLS_UCAST;
    end else if (in_ready) begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_accept <= d_acc;
        res_hit    <= m_hit;
        res_idx    <= m_idx;
        res_class  <= d_cls;
      end
    end
  end

endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk
  import daf_pkg::*;
#(
  parameter int  N_ENTRIES = 16,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             in_valid,
  input logic             in_ready,
  input logic [47:0]      in_addr,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_accept,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_idx,
  input logic [1:0]       res_class
);

  logic cfg_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_seen <= 1'b0;
    else if (reg_we) cfg_seen <= 1'b1;
  end

  // R1
  unconf_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !cfg_seen |-> !res_accept);

  // R4
  bcast_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (&in_addr) |=> res_class == CLS_BCAST);

  // R8
  idx_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_idx == '0);

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> res_valid);

  // R9
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> res_valid && !res_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_accept) &&
      $stable(res_hit) && $stable(res_idx) && $stable(res_class));

endmodule

bind dest_addr_filter dest_addr_filter_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_addr    (in_addr),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_accept (res_accept),
  .res_hit    (res_hit),
  .res_idx    (res_idx),
  .res_class  (res_class)
);

// File: tb/dest_addr_filter_bench.sv
`timescale 1ns/1ps
module dest_addr_filter_bench;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        in_valid;
  logic        in_ready;
  logic [47:0] in_addr;
  logic        res_valid;
  logic        res_ready;
  logic        res_accept;
  logic        res_hit;
  logic [3:0]  res_idx;
  logic [1:0]  res_class;

  int checks = 0;
  int errors = 0;

  localparam logic [47:0] MA = 48'h02_1A_3B_4C_5D_6E;
  localparam logic [47:0] MB = 48'h00_11_22_33_44_55;
  localparam logic [47:0] MC = 48'h0A_0B_0C_0D_0E_0F;
  localparam logic [47:0] MM = 48'h01_00_5E_00_00_FB;
  localparam logic [47:0] BC = 48'hFF_FF_FF_FF_FF_FF;

  always #2 clk = ~clk;

  dest_addr_filter #(.N_ENTRIES(N), .ADDR_W(8)) u_dest_addr_filter (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .in_valid, .in_ready, .in_addr, .res_valid, .res_ready,
    .res_accept, .res_hit, .res_idx, .res_class
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_entry(input int i, input logic [47:0] m);
    reg_wr(8'(8 + 8 * i), m[47:16]);
    reg_wr(8'(12 + 8 * i), {m[15:0], 16'h0});
  endtask

  // offer one address, sample verdict at the following negedge
  task automatic look(input string tag, input logic [47:0] a, input logic acc,
                      input logic hit, input logic [3:0] idx, input logic [1:0] cls);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, 64'(res_valid), 64'd1);
    chk({tag, " accept"}, 64'(res_accept), 64'(acc));
    chk({tag, " hit"}, 64'(res_hit), 64'(hit));
    chk({tag, " idx"}, 64'(res_idx), 64'(idx));
    chk({tag, " class"}, 64'(res_class), 64'(cls));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 res_valid after reset", 64'(res_valid), 64'd0);
    chk("R1 in_ready after reset", 64'(in_ready), 64'd1);
    reg_rd(8'h00, d); chk("R1 cmd reset", 64'(d), 64'd0);
    reg_rd(8'h04, d); chk("R1 enables reset", 64'(d), 64'd0);
    look("R1 bcast unconfigured", BC, 1'b0, 1'b0, 4'd0, 2'd2);
    look("R1 ucast unconfigured", MA, 1'b0, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    reg_wr(8'h00, 32'hFFFF_FFFF); reg_rd(8'h00, d); chk("R2 cmd readback", 64'(d), 64'h1F);
    reg_wr(8'h04, 32'hFFFF_FFFF); reg_rd(8'h04, d); chk("R2 enable readback", 64'(d), 64'hFFFF);
    reg_wr(8'h30, 32'h1234_5678); reg_rd(8'h30, d); chk("R2 entry5 high", 64'(d), 64'h1234_5678);
    reg_wr(8'h34, 32'h9ABC_DEF0); reg_rd(8'h34, d); chk("R2 entry5 low", 64'(d), 64'h9ABC_0000);
    reg_wr(8'h88, 32'hDEAD_BEEF); reg_rd(8'h88, d); chk("R2 unmapped read", 64'(d), 64'd0);
    reg_rd(8'h08, d); chk("R2 unmapped write no effect", 64'(d), 64'd0);
    reg_wr(8'h00, 32'h0);
    reg_wr(8'h04, 32'h0);
  endtask

  task automatic t_packing;
    logic [31:0] d;
    set_entry(3, MA);
    reg_rd(8'h20, d); chk("R3 high word bytes 0..3", 64'(d), 64'h021A_3B4C);
    reg_rd(8'h24, d); chk("R3 low word bytes 4,5", 64'(d), 64'h5D6E_0000);
    reg_wr(8'h04, 32'h0000_0008);
    reg_wr(8'h00, 32'h10);
    look("R3 exact match", MA, 1'b1, 1'b1, 4'd3, 2'd0);
    look("R3 byte5 differs", {MA[47:8], 8'h6F}, 1'b0, 1'b0, 4'd0, 2'd0);
    look("R3 byte order swapped", 48'h6E_5D_4C_3B_1A_02, 1'b0, 1'b0, 4'd0, 2'd0);
  endtask

  task automatic t_classes;
    reg_wr(8'h00, 32'h01);
    look("R5 uc-all unicast", MC, 1'b1, 1'b0, 4'd0, 2'd0);
    look("R5 uc-all multicast", MM, 1'b0, 1'b0, 4'd0, 2'd1);
    look("R5 uc-all broadcast", BC, 1'b0, 1'b0, 4'd0, 2'd2);
    reg_wr(8'h00, 32'h02);
    look("R5 mc-all multicast", MM, 1'b1, 1'b0, 4'd0, 2'd1);
    look("R4 broadcast not multicast", BC, 1'b0, 1'b0, 4'd0, 2'd2);
    look("R5 mc-all unicast", MC, 1'b0, 1'b0, 4'd0, 2'd0);
    reg_wr(8'h00, 32'h04);
    look("R5 bc-all broadcast", BC, 1'b1, 1'b0, 4'd0, 2'd2);
    look("R4 near-broadcast is multicast", {BC[47:1], 1'b0}, 1'b0, 1'b0, 4'd0, 2'd1);
  endtask

  task automatic t_table;
    set_entry(7, MB);
    reg_wr(8'h04, 32'h0000_0008);
    reg_wr(8'h00, 32'h10);
    look("R6 disabled entry no match", MB, 1'b0, 1'b0, 4'd0, 2'd0);
    reg_wr(8'h04, 32'h0000_0088);
    look("R6 enabled entry7 match", MB, 1'b1, 1'b1, 4'd7, 2'd0);
    reg_wr(8'h00, 32'h00);
    look("R8 hit reported without compare", MA, 1'b0, 1'b1, 4'd3, 2'd0);
  endtask

  task automatic t_compl;
    reg_wr(8'h00, 32'h18);
    look("R7 complement match rejects", MA, 1'b0, 1'b1, 4'd3, 2'd0);
    look("R7 complement miss accepts", MC, 1'b1, 1'b0, 4'd0, 2'd0);
    reg_wr(8'h00, 32'h1C);
    look("R7 complement with bc-all", BC, 1'b1, 1'b0, 4'd0, 2'd2);
    reg_wr(8'h00, 32'h1F);
    look("R7 promiscuous overrides match reject", MA, 1'b1, 1'b1, 4'd3, 2'd0);
    look("R7 promiscuous multicast", MM, 1'b1, 1'b0, 4'd0, 2'd1);
  endtask

  task automatic t_prio;
    set_entry(9, MA);
    reg_wr(8'h04, 32'h0000_0208);
    reg_wr(8'h00, 32'h10);
    look("R8 lowest index wins", MA, 1'b1, 1'b1, 4'd3, 2'd0);
    reg_wr(8'h04, 32'h0000_0200);
    look("R8 next entry after disable", MA, 1'b1, 1'b1, 4'd9, 2'd0);
  endtask

  task automatic t_backpressure;
    reg_wr(8'h00, 32'h04);
    @(negedge clk);
    res_ready = 1'b0; in_valid = 1'b1; in_addr = BC;
    @(negedge clk);
    chk("R9 stalled valid", 64'(res_valid), 64'd1);
    chk("R9 in_ready low in stall", 64'(in_ready), 64'd0);
    in_addr = MC;
    repeat (2) @(negedge clk);
    chk("R9 held accept", 64'(res_accept), 64'd1);
    chk("R9 held class", 64'(res_class), 64'd2);
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next taken on drain", 64'(res_valid), 64'd1);
    chk("R9 next class", 64'(res_class), 64'd0);
    chk("R9 next accept", 64'(res_accept), 64'd0);
    @(negedge clk);
    chk("R9 empty after drain", 64'(res_valid), 64'd0);
  endtask

  task automatic t_same_cycle;
    reg_wr(8'h04, 32'h0000_0008);
    reg_wr(8'h00, 32'h10);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h0;
    in_valid = 1'b1; in_addr = MA;
    @(negedge clk);
    reg_we = 1'b0; in_valid = 1'b0;
    chk("R10 lookup sees old entry accept", 64'(res_accept), 64'd1);
    chk("R10 lookup sees old entry hit", 64'(res_hit), 64'd1);
    chk("R10 lookup sees old entry idx", 64'(res_idx), 64'd3);
    look("R10 after write no match", MA, 1'b0, 1'b0, 4'd0, 2'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    in_valid = 1'b0; in_addr = '0; res_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_packing();
    t_classes();
    t_table();
    t_compl();
    t_prio();
    t_backpressure();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule